// File: doc/BRIEF.md
# Key Combination Hold Detector

This block watches four active-low key lines (power button and three keys) and reports when a programmed set of them has been pressed together and held for a programmed time. The selected key lines are merged into one trigger signal. That trigger is low only while every selected key is down. The block arms on a falling edge of the trigger. It confirms the press with a two-point debounce: one sample when the debounce window opens and one when it closes, with no filtering in between. It then requires the trigger to stay low for a hold count. An optional pre-condition key set must be held at a steady low level for its own hold count before the channel will arm at all.

When a detection occurs, the block raises the enabled action requests:
- a battery-disable output that stays high until reset,
- a one-cycle interrupt pulse together with a one-cycle wakeup pulse,
- a one-cycle request for an external reset-pulse generator,
- a system reset request that stays high until reset.

A sticky status bit records that a detection happened.

Each detector is a state machine with four states:
- **IDLE** moves to DEBOUNCE on *arm*. For the combo this is a falling edge while enabled. For the pre-condition it is a low level while enabled.
- **DEBOUNCE** counts the window, then takes *confirm* to HOLD if the signal is low, or *bounce* back to IDLE if it is high.
- **HOLD** counts low samples. It takes *qualify* to DONE after the hold count, or *abort* to IDLE on any high sample.
- **DONE** takes *release* to IDLE when the signal goes high.

Losing the enable (*drop*) forces IDLE from any state. The combo detector is enabled only while the pre-condition is met and at least one trigger key is selected.

Top module: `key_combo_channel`

## Requirements
- R1: Key bit 0 is the power button and bits 1 to 3 are key0 to key2. A key line at 0 means pressed. The trigger is pressed only when every key whose `trig_sel` bit is 1 reads 0.
- R2: The combo arms only on a high-to-low change of the trigger while enabled. A trigger that is already low when the channel becomes enabled never fires.
- R3: With a debounce count D, the trigger is sampled at the edge that arms the channel and again D+1 edges later. A release and re-press between those samples is not seen, and a high level at the closing sample returns the channel to IDLE.
- R4: With hold count H ≥ 1 and no pre-condition, a detection takes effect at the (D+H+2)-th rising edge after the key press is applied. Any release during HOLD aborts, and firing again then needs a new falling edge.
- R5: The pre-condition is met when every key selected by `pre_sel` reads 0 through its own debounce and `pre_hold_cycles` hold. The combo cannot arm before then. A `pre_sel` of 0 counts as met at once.
- R6: If the pre-condition keys are released, a combo in progress is abandoned and does not fire.
- R7: With `trig_sel` equal to 0 the channel never fires.
- R8: `act_en` bit 0 set: a detection drives `bat_disable_o` high until reset.
- R9: `act_en` bit 1 set: a detection gives a one-cycle `irq_o` pulse and a one-cycle `wake_o` pulse.
- R10: `act_en` bit 2 set: a detection gives a one-cycle `ec_rst_req_o` pulse.
- R11: `act_en` bit 3 set: a detection drives `sys_rst_req_o` high until reset.
- R12: Every detection sets `hit_status_o`, whatever `act_en` holds, and it stays set until reset.
- R13: During and right after reset, all outputs are 0.
- R14: After a detection, keeping the keys held produces no further detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| keys_n | input | NUM_KEYS | Active-low key lines, polarity already adjusted |
| trig_sel | input | NUM_KEYS | Keys that form the trigger combination |
| pre_sel | input | NUM_KEYS | Keys that form the pre-condition |
| deb_cycles | input | CNT_W | Debounce window length, shared by both detectors |
| pre_hold_cycles | input | CNT_W | Pre-condition hold count |
| combo_hold_cycles | input | CNT_W | Combo hold count |
| act_en | input | NUM_ACT | Action enables: battery, interrupt, reset pulse, system reset |
| bat_disable_o | output | 1 | Sticky battery-disable request |
| irq_o | output | 1 | Interrupt pulse |
| wake_o | output | 1 | Wakeup pulse sent with the interrupt |
| ec_rst_req_o | output | 1 | Request to the reset-pulse generator |
| sys_rst_req_o | output | 1 | Sticky system reset request |
| hit_status_o | output | 1 | Sticky detection status |

## Verification
The bench builds the block with `CNT_W` set to 8 and `NUM_KEYS` left at 4. Debounce and hold counts of 2 to 5 cycles then make each state path of both detectors reachable within tens of cycles. This lets the bench predict the exact firing edge and land a release or re-press inside a specific debounce or hold window. The 8-bit counter also keeps timer state small while still covering every state transition named above.

// File: rtl/combo_pkg.sv
package combo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_HOLD,
        ST_DONE
    } det_state_t;

    localparam int NUM_ACT    = 4;
    localparam int ACT_BAT    = 0;
    localparam int ACT_IRQ    = 1;
    localparam int ACT_ECRST  = 2;
    localparam int ACT_SYSRST = 3;

endpackage

// File: rtl/combo_key_merge.sv
module combo_key_merge #(
    parameter int NUM_KEYS = 4
) (
    input  logic [NUM_KEYS-1:0] keys_n,
    input  logic [NUM_KEYS-1:0] trig_sel,
    input  logic [NUM_KEYS-1:0] pre_sel,
    output logic                trig_n,
    output logic                pre_n,
    output logic                trig_any,
    output logic                pre_any
);

    logic [NUM_KEYS-1:0] trig_bits;
    logic [NUM_KEYS-1:0] pre_bits;

    // A masked-out key contributes 0, so it never holds the merged line high.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_mask
        assign trig_bits[k] = keys_n[k] & trig_sel[k];
        assign pre_bits[k]  = keys_n[k] & pre_sel[k];
    end

    assign trig_n   = |trig_bits;
    assign pre_n    = |pre_bits;
    assign trig_any = |trig_sel;
    assign pre_any  = |pre_sel;

endmodule

// File: rtl/combo_det_fsm.sv
module combo_det_fsm
    import combo_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter bit EDGE_ARM = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sig_n,
    input  logic [CNT_W-1:0] deb_cycles,
    input  logic [CNT_W-1:0] hold_cycles,
    output logic             done_o
);

    det_state_t       state, state_nxt;
    logic [CNT_W-1:0] timer, timer_nxt;
    logic [CNT_W:0]   timer_inc;
    logic             arm;

    assign timer_inc = {1'b0, timer} + {{CNT_W{1'b0}}, 1'b1};

    // Arm condition: a falling edge for the combo, a low level for the pre-condition.
    if (EDGE_ARM) begin : g_edge
        logic prev_n;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_n <= 1'b1;
            else        prev_n <= sig_n;
        end
        assign arm = prev_n & ~sig_n;

        // R2
        no_arm_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_IDLE && !(prev_n && !sig_n)) |=> (state == ST_IDLE));
    end else begin : g_level
        assign arm = ~sig_n;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            state <= state_nxt;
            timer <= timer_nxt;
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state;
        timer_nxt = timer;
        unique case (state)
            ST_IDLE: begin
                timer_nxt = '0;
                if (arm) state_nxt = ST_DEBOUNCE;
            end
            ST_DEBOUNCE: begin
                // Only the window-closing sample matters.
                if (timer >= deb_cycles) begin
                    timer_nxt = '0;
                    state_nxt = sig_n ? ST_IDLE : ST_HOLD;
                end else begin
                    timer_nxt = timer_inc[CNT_W-1:0];
                end
            end
            ST_HOLD: begin
                if (sig_n) begin
                    timer_nxt = '0;
                    state_nxt = ST_IDLE;
                end else if (timer_inc >= {1'b0, hold_cycles}) begin
                    timer_nxt = '0;
                    state_nxt = ST_DONE;
                end else begin
                    timer_nxt = timer_inc[CNT_W-1:0];
                end
            end
            ST_DONE: begin
                if (sig_n) state_nxt = ST_IDLE;
            end
        endcase
        if (!en) begin
            state_nxt = ST_IDLE;
            timer_nxt = '0;
        end
    end

    // Outputs.
    if (EDGE_ARM) begin : g_pulse
        always_comb begin
            done_o = (state == ST_HOLD) && (state_nxt == ST_DONE);
        end
    end else begin : g_lvl
        always_comb begin
            done_o = en && (state == ST_DONE) && !sig_n;
        end
    end

    // R6
    en_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE));

    // R4
    hold_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && sig_n) |=> (state == ST_IDLE));

    // R3
    deb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEBOUNCE && en && timer < deb_cycles) |=> (state == ST_DEBOUNCE));

endmodule

// File: rtl/combo_action.sv
module combo_action
    import combo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [NUM_ACT-1:0] act_en,
    output logic               bat_disable_o,
    output logic               irq_o,
    output logic               wake_o,
    output logic               ec_rst_req_o,
    output logic               sys_rst_req_o,
    output logic               hit_status_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bat_disable_o <= 1'b0;
            irq_o         <= 1'b0;
            wake_o        <= 1'b0;
            ec_rst_req_o  <= 1'b0;
            sys_rst_req_o <= 1'b0;
            hit_status_o  <= 1'b0;
        end else begin
            irq_o        <= fire & act_en[ACT_IRQ];
            wake_o       <= fire & act_en[ACT_IRQ];
            ec_rst_req_o <= fire & act_en[ACT_ECRST];
            if (fire) begin
                hit_status_o <= 1'b1;
                if (act_en[ACT_BAT])    bat_disable_o <= 1'b1;
                if (act_en[ACT_SYSRST]) sys_rst_req_o <= 1'b1;
            end
        end
    end

    // R8
    bat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bat_disable_o |=> bat_disable_o);

    // R11
    sys_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req_o |=> sys_rst_req_o);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R12
    status_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> hit_status_o);

endmodule

// File: rtl/key_combo_channel.sv
module key_combo_channel
    import combo_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    parameter int CNT_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_KEYS-1:0] keys_n,
    input  logic [NUM_KEYS-1:0] trig_sel,
    input  logic [NUM_KEYS-1:0] pre_sel,
    input  logic [CNT_W-1:0]    deb_cycles,
    input  logic [CNT_W-1:0]    pre_hold_cycles,
    input  logic [CNT_W-1:0]    combo_hold_cycles,
    input  logic [NUM_ACT-1:0]  act_en,
    output logic                bat_disable_o,
    output logic                irq_o,
    output logic                wake_o,
    output logic                ec_rst_req_o,
    output logic                sys_rst_req_o,
    output logic                hit_status_o
);

    logic trig_n, pre_n, trig_any, pre_any;
    logic pre_met, pre_ok, combo_en, combo_fire;

    combo_key_merge #(.NUM_KEYS(NUM_KEYS)) u_merge (
        .keys_n   (keys_n),
        .trig_sel (trig_sel),
        .pre_sel  (pre_sel),
        .trig_n   (trig_n),
        .pre_n    (pre_n),
        .trig_any (trig_any),
        .pre_any  (pre_any)
    );

    combo_det_fsm #(.CNT_W(CNT_W), .EDGE_ARM(1'b0)) u_pre_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (pre_any),
        .sig_n       (pre_n),
        .deb_cycles  (deb_cycles),
        .hold_cycles (pre_hold_cycles),
        .done_o      (pre_met)
    );

    assign pre_ok   = !pre_any || pre_met;
    assign combo_en = pre_ok && trig_any;

    combo_det_fsm #(.CNT_W(CNT_W), .EDGE_ARM(1'b1)) u_combo_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (combo_en),
        .sig_n       (trig_n),
        .deb_cycles  (deb_cycles),
        .hold_cycles (combo_hold_cycles),
        .done_o      (combo_fire)
    );

    combo_action u_action (
        .clk           (clk),
        .rst_n         (rst_n),
        .fire          (combo_fire),
        .act_en        (act_en),
        .bat_disable_o (bat_disable_o),
        .irq_o         (irq_o),
        .wake_o        (wake_o),
        .ec_rst_req_o  (ec_rst_req_o),
        .sys_rst_req_o (sys_rst_req_o),
        .hit_status_o  (hit_status_o)
    );

    // R7
    trig_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_status_o) |-> $past(trig_sel != '0));

    // R5
    pre_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        combo_fire |-> (!pre_any || !pre_n));

endmodule

// File: tb/key_combo_channel_bench.sv
module key_combo_channel_bench;

    localparam int NK = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NK-1:0] keys_n, trig_sel, pre_sel;
    logic [CW-1:0] deb_cycles, pre_hold_cycles, combo_hold_cycles;
    logic [3:0]    act_en;
    logic          bat_disable_o, irq_o, wake_o, ec_rst_req_o, sys_rst_req_o, hit_status_o;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int lat;
    int c0;

    always #10 clk = ~clk;

    key_combo_channel #(.NUM_KEYS(NK), .CNT_W(CW)) u_key_combo_channel (
        .clk(clk), .rst_n(rst_n), .keys_n(keys_n), .trig_sel(trig_sel), .pre_sel(pre_sel),
        .deb_cycles(deb_cycles), .pre_hold_cycles(pre_hold_cycles),
        .combo_hold_cycles(combo_hold_cycles), .act_en(act_en),
        .bat_disable_o(bat_disable_o), .irq_o(irq_o), .wake_o(wake_o),
        .ec_rst_req_o(ec_rst_req_o), .sys_rst_req_o(sys_rst_req_o), .hit_status_o(hit_status_o)
    );

    always @(negedge clk) if (irq_o === 1'b1) irq_cnt++;

    // Each entry is {trig_sel[3:0], keys_n[3:0], expect_fire}.
    localparam logic [8:0] VEC [0:6] = '{
        {4'b0011, 4'b1100, 1'b1},
        {4'b0011, 4'b1110, 1'b0},
        {4'b1000, 4'b0111, 1'b1},
        {4'b1111, 4'b0000, 1'b1},
        {4'b1111, 4'b0001, 1'b0},
        {4'b0101, 4'b1010, 1'b1},
        {4'b0101, 4'b0111, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic outs_zero(input string req);
        chk(req, {26'd0, bat_disable_o, irq_o, wake_o, ec_rst_req_o, sys_rst_req_o, hit_status_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        keys_n = 4'hF;
        trig_sel = '0;
        pre_sel = '0;
        deb_cycles = 8'd2;
        pre_hold_cycles = 8'd5;
        combo_hold_cycles = 8'd3;
        act_en = 4'b1111;
        tick(3);
        outs_zero("R13 in reset");
        rst_n = 1'b1;
        tick(1);
        outs_zero("R13 after reset");
        lat = 2 + 3 + 2;

        // R1 / R4 / R9 / R10: vector table, exact firing edge.
        foreach (VEC[i]) begin
            trig_sel = VEC[i][8:5];
            tick(2);
            keys_n = VEC[i][4:1];
            tick(lat - 1);
            chk("R4 not early", irq_o, 0);
            tick(1);
            chk("R1 irq", irq_o, VEC[i][0]);
            chk("R10 ec_rst_req", ec_rst_req_o, VEC[i][0]);
            chk("R9 wake", wake_o, VEC[i][0]);
            if (VEC[i][0]) begin
                tick(1);
                chk("R9 irq one cycle", irq_o, 0);
                chk("R10 ec pulse one cycle", ec_rst_req_o, 0);
            end
            keys_n = 4'hF;
            tick(3);
        end

        // R14: holding after a detection does not re-fire.
        trig_sel = 4'b0011;
        keys_n = 4'b1100;
        tick(lat);
        c0 = irq_cnt;
        tick(30);
        chk("R14 no re-fire while held", irq_cnt, c0);
        keys_n = 4'hF;
        tick(3);
        keys_n = 4'b1100;
        tick(lat);
        chk("R14 fires after release", irq_cnt, c0 + 1);
        keys_n = 4'hF;
        tick(3);

        // R7 / R2
        trig_sel = '0;
        tick(2);
        c0 = irq_cnt;
        keys_n = 4'b1100;
        tick(30);
        chk("R7 empty trigger select", irq_cnt, c0);
        trig_sel = 4'b0011;
        tick(30);
        chk("R2 already low when enabled", irq_cnt, c0);
        keys_n = 4'hF;
        tick(3);

        // R3: mid-window bounce is not seen.
        deb_cycles = 8'd4;
        keys_n = 4'b1100;
        tick(2);
        keys_n = 4'hF;
        tick(2);
        keys_n = 4'b1100;
        tick(4);
        chk("R3 not early", irq_o, 0);
        tick(1);
        chk("R3 mid-window bounce ignored", irq_o, 1);
        keys_n = 4'hF;
        tick(3);
        c0 = irq_cnt;
        keys_n = 4'b1100;
        tick(3);
        keys_n = 4'hF;
        tick(30);
        chk("R3 high at window close", irq_cnt, c0);
        deb_cycles = 8'd2;

        // R4: release during hold aborts.
        keys_n = 4'b1100;
        tick(5);
        keys_n = 4'hF;
        tick(20);
        chk("R4 abort in hold", irq_cnt, c0);
        keys_n = 4'b1100;
        tick(lat - 1);
        chk("R4 re-press not early", irq_o, 0);
        tick(1);
        chk("R4 re-press fires", irq_o, 1);
        keys_n = 4'hF;
        tick(3);

        // R5: pre-condition on key2 (bit 3).
        pre_sel = 4'b1000;
        c0 = irq_cnt;
        keys_n = 4'b0111;
        tick(3);
        keys_n = 4'b0100;
        tick(30);
        chk("R5 edge before pre-condition met", irq_cnt, c0);
        keys_n = 4'b0111;
        tick(2);
        keys_n = 4'b0100;
        tick(lat - 1);
        chk("R5 not early", irq_o, 0);
        tick(1);
        chk("R5 fires with pre-condition", irq_o, 1);

        // R6: losing the pre-condition during hold.
        keys_n = 4'b0111;
        tick(3);
        c0 = irq_cnt;
        keys_n = 4'b0100;
        tick(5);
        keys_n = 4'b1100;
        tick(20);
        chk("R6 pre-condition lost", irq_cnt, c0);
        keys_n = 4'hF;
        pre_sel = '0;
        tick(3);

        // R12 / R8 / R11
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        act_en = 4'b0000;
        tick(2);
        c0 = irq_cnt;
        keys_n = 4'b1100;
        tick(lat);
        chk("R12 status without actions", hit_status_o, 1);
        chk("R8 battery disabled off", bat_disable_o, 0);
        chk("R11 system reset disabled off", sys_rst_req_o, 0);
        chk("R9 irq disabled off", irq_cnt, c0);
        keys_n = 4'hF;
        tick(3);
        act_en = 4'b1001;
        keys_n = 4'b1100;
        tick(lat);
        chk("R8 battery set", bat_disable_o, 1);
        chk("R11 system reset set", sys_rst_req_o, 1);
        keys_n = 4'hF;
        tick(20);
        chk("R8 battery sticky", bat_disable_o, 1);
        chk("R11 system reset sticky", sys_rst_req_o, 1);
        chk("R12 status sticky", hit_status_o, 1);
        rst_n = 1'b0;
        tick(1);
        outs_zero("R13 reset clears sticky");
        rst_n = 1'b1;
        tick(2);

        finish_run();
    end

endmodule